// File: doc/BRIEF.md
# Flash Program/Erase Status Tracker

This block keeps the status word and decides the outcome of every program or erase operation that a flash write controller runs. A command decoder upstream hands it one decoded request per clock (program, erase, suspend, resume, clear status) together with a target block index. A behavioural array model supplies a verify pass/fail flag, and a supply-valid input reports whether the high-voltage rail is usable. Per-block lock bits come from the protection logic.

The block sequences each operation as one or more timed steps. It checks the lock and the supply when a program or erase is accepted. It checks the supply again on the final cycle of every step, right before the verify result is taken. It then either finishes cleanly, retries an erase pulse, or latches an error bit. Software polls the 8-bit status word. Bit 7 says whether the controller is ready, and the other bits record suspensions, failures and aborts until they are cleared.

Top module: `flash_status_tracker`

## Requirements
- R1: The status word is laid out as follows: bit 7 ready, bit 6 erase suspended, bit 5 erase failure, bit 4 program failure, bit 3 supply-low abort, bit 2 program suspended, bit 1 locked-block abort, bit 0 reserved. Bit 0 always reads 0. After reset the status word is 8'h80 and op_abort is 0.
- R2: Request codes on req_op are 0 idle, 1 program, 2 erase, 3 suspend, 4 resume, 5 clear status, and 6 or 7 invalid. A program or erase is accepted when the block is ready and nothing is suspended. Bit 7 then reads 0 from the next cycle for STEP_CYCLES cycles per pulse, and the ready output always equals bit 7.
- R3: A suspend while busy sets bit 7 on the next cycle, together with bit 6 for an erase or bit 2 for a program. The flag holds until a resume, which makes the block busy again. The suspend cycle does not advance the step, and the interrupted step then runs its remaining cycles. A suspend takes priority over a step that would end in the same cycle. A suspend while ready and a resume with nothing suspended change nothing.
- R4: A program whose verify fails on the final cycle of its step sets bit 4 and returns to ready.
- R5: An erase whose verify fails starts another pulse, up to PULSE_MAX pulses. A failure on the last pulse sets bit 5. A pass on any pulse ends the erase cleanly.
- R6: A program or erase aimed at a locked block, or at an index at or beyond NUM_BLOCKS, does not become busy. It sets bit 1 and raises op_abort for the cycle in which bit 1 first shows.
- R7: The supply is sampled only at acceptance and on the final cycle of each step. A low sample sets bit 3, raises op_abort and returns to ready. A low supply at any other cycle has no effect.
- R8: An invalid request code while not busy, or a program or erase while an operation is suspended, is a command-sequence error. It sets bits 4 and 5 with bit 7 at 1, and any suspended operation stays suspended.
- R9: Bits 1, 3, 4 and 5 are sticky across new operations. A clear-status request while not busy clears them and leaves the suspend flags untouched. While busy, every request other than suspend is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 3 | Decoded request code |
| req_block | input | BLK_W | Target block index of a program or erase |
| lock_bits | input | NUM_BLOCKS | One lock bit per block, 1 = locked |
| supply_ok | input | 1 | Programming supply usable |
| verify_pass | input | 1 | Array verify result for the current step |
| status | output | 8 | Status word |
| ready | output | 1 | Copy of status bit 7 |
| op_abort | output | 1 | One-cycle pulse on a lock or supply abort |

## Verification
Every request, supply sample and verify result is taken on a rising edge, and its effect on status and op_abort appears right after that edge. The only exception is a busy step, whose end comes STEP_CYCLES edges after it was loaded. The bench therefore drives inputs on the falling edge and advances a reference model on the next rising edge. It compares the outputs with that model at the following falling edge. The directed cases count busy cycles between acceptance and ready, so pulse lengths and retry counts are checked at the exact cycle they are due.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_ERASE  = 3'd2,
      OP_SUSP   = 3'd3,
      OP_RESUME = 3'd4,
      OP_CLEAR  = 3'd5,
      OP_BAD6   = 3'd6,
      OP_BAD7   = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      MODE_READY = 2'd0,
      MODE_BUSY  = 2'd1,
      MODE_HALT  = 2'd2
   } mode_e;

   localparam int unsigned SB_READY = 7;
   localparam int unsigned SB_ESUS  = 6;
   localparam int unsigned SB_EERR  = 5;
   localparam int unsigned SB_PERR  = 4;
   localparam int unsigned SB_VLOW  = 3;
   localparam int unsigned SB_PSUS  = 2;
   localparam int unsigned SB_LOCK  = 1;
   localparam int unsigned SB_RSVD  = 0;

   localparam int unsigned STICKY_N = 4;

   typedef struct packed {
      logic set_eerr;
      logic set_perr;
      logic set_vlow;
      logic set_lock;
      logic clr_err;
   } evt_t;

endpackage

// File: rtl/flash_step_timer.sv
module flash_step_timer #(
   parameter int unsigned STEP_CYCLES = 4,
   parameter int unsigned PULSE_MAX   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_first,
   input  logic load_next,
   input  logic tick,
   output logic last_cycle,
   output logic last_pulse
);

   localparam int unsigned CNT_W = $clog2(STEP_CYCLES + 1);
   localparam int unsigned PLS_W = $clog2(PULSE_MAX + 1);

   generate
      if (STEP_CYCLES < 1) begin : g_bad_step
         $error("flash_step_timer: STEP_CYCLES must be at least 1");
      end
      if (PULSE_MAX < 1) begin : g_bad_pulse
         $error("flash_step_timer: PULSE_MAX must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_first || load_next) begin
         cnt_q <= CNT_W'(STEP_CYCLES);
      end else if (tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last_cycle = (cnt_q == CNT_W'(1));

   generate
      if (PULSE_MAX == 1) begin : g_single_pulse
         assign last_pulse = 1'b1;
      end else begin : g_multi_pulse
         logic [PLS_W-1:0] pls_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pls_q <= '0;
            end else if (load_first) begin
               pls_q <= PLS_W'(1);
            end else if (load_next) begin
               pls_q <= pls_q + 1'b1;
            end
         end
         assign last_pulse = (pls_q == PLS_W'(PULSE_MAX));
      end
   endgenerate

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
   import flash_stat_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  op_e   op_i,
   input  logic  lock_hit,
   input  logic  supply_ok,
   input  logic  verify_pass,
   input  logic  last_cycle,
   input  logic  last_pulse,
   output logic  load_first,
   output logic  load_next,
   output logic  tick,
   output mode_e mode_o,
   output logic  erase_o,
   output evt_t  evt_o,
   output logic  abort_o
);

   mode_e mode_q, mode_d;
   logic  erase_q, erase_d;
   logic  abort_q, abort_d;

   always_comb begin
      mode_d     = mode_q;
      erase_d    = erase_q;
      abort_d    = 1'b0;
      evt_o      = '0;
      load_first = 1'b0;
      load_next  = 1'b0;
      tick       = 1'b0;
      case (mode_q)
         MODE_BUSY: begin
            if (op_i == OP_SUSP) begin
               mode_d = MODE_HALT;
            end else if (!last_cycle) begin
               tick = 1'b1;
            end else if (!supply_ok) begin
               evt_o.set_vlow = 1'b1;
               abort_d        = 1'b1;
               mode_d         = MODE_READY;
            end else if (verify_pass) begin
               mode_d = MODE_READY;
            end else if (!erase_q) begin
               evt_o.set_perr = 1'b1;
               mode_d         = MODE_READY;
            end else if (last_pulse) begin
               evt_o.set_eerr = 1'b1;
               mode_d         = MODE_READY;
            end else begin
               load_next = 1'b1;
            end
         end
         default: begin
            case (op_i)
               OP_PROG, OP_ERASE: begin
                  if (mode_q == MODE_HALT) begin
                     evt_o.set_perr = 1'b1;
                     evt_o.set_eerr = 1'b1;
                  end else if (lock_hit) begin
                     evt_o.set_lock = 1'b1;
                     abort_d        = 1'b1;
                  end else if (!supply_ok) begin
                     evt_o.set_vlow = 1'b1;
                     abort_d        = 1'b1;
                  end else begin
                     load_first = 1'b1;
                     mode_d     = MODE_BUSY;
                     erase_d    = (op_i == OP_ERASE);
                  end
               end
               OP_RESUME: begin
                  if (mode_q == MODE_HALT) begin
                     mode_d = MODE_BUSY;
                  end
               end
               OP_CLEAR: begin
                  evt_o.clr_err = 1'b1;
               end
               OP_BAD6, OP_BAD7: begin
                  evt_o.set_perr = 1'b1;
                  evt_o.set_eerr = 1'b1;
               end
               default: begin
               end
            endcase
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_READY;
         erase_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         erase_q <= erase_d;
         abort_q <= abort_d;
      end
   end

   assign mode_o  = mode_q;
   assign erase_o = erase_q;
   assign abort_o = abort_q;

endmodule

// File: rtl/flash_status_bits.sv
module flash_status_bits
   import flash_stat_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  evt_t       evt,
   input  mode_e      mode,
   input  logic       is_erase,
   output logic [7:0] status
);

   logic [STICKY_N-1:0] sticky_q;
   logic [STICKY_N-1:0] set_vec;

   // sticky order: 0 lock, 1 supply low, 2 program fail, 3 erase fail
   assign set_vec = {evt.set_eerr, evt.set_perr, evt.set_vlow, evt.set_lock};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
      end else begin
         for (int i = 0; i < int'(STICKY_N); i++) begin
            if (set_vec[i]) begin
               sticky_q[i] <= 1'b1;
            end else if (evt.clr_err) begin
               sticky_q[i] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      status          = '0;
      status[SB_READY] = (mode != MODE_BUSY);
      status[SB_ESUS]  = (mode == MODE_HALT) && is_erase;
      status[SB_PSUS]  = (mode == MODE_HALT) && !is_erase;
      status[SB_LOCK]  = sticky_q[0];
      status[SB_VLOW]  = sticky_q[1];
      status[SB_PERR]  = sticky_q[2];
      status[SB_EERR]  = sticky_q[3];
      status[SB_RSVD]  = 1'b0;
   end

endmodule

// File: rtl/flash_status_tracker.sv
module flash_status_tracker
   import flash_stat_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS  = 16,
   parameter int unsigned STEP_CYCLES = 4,
   parameter int unsigned PULSE_MAX   = 8,
   localparam int unsigned BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            req_op,
   input  logic [BLK_W-1:0]      req_block,
   input  logic [NUM_BLOCKS-1:0] lock_bits,
   input  logic                  supply_ok,
   input  logic                  verify_pass,
   output logic [7:0]            status,
   output logic                  ready,
   output logic                  op_abort
);

   generate
      if (NUM_BLOCKS < 1) begin : g_bad_blocks
         $error("flash_status_tracker: NUM_BLOCKS must be at least 1");
      end
   endgenerate

   logic  lock_hit;
   logic  load_first, load_next, tick;
   logic  last_cycle, last_pulse;
   mode_e mode;
   logic  is_erase;
   evt_t  evt;

   // out-of-range block index is treated as locked
   generate
      if (NUM_BLOCKS == 1) begin : g_lock_one
         assign lock_hit = lock_bits[0] | req_block[0];
      end else if ((1 << BLK_W) == NUM_BLOCKS) begin : g_lock_pow2
         assign lock_hit = lock_bits[req_block];
      end else begin : g_lock_range
         assign lock_hit = (int'(req_block) >= int'(NUM_BLOCKS)) ? 1'b1 : lock_bits[req_block];
      end
   endgenerate

   flash_step_timer #(
      .STEP_CYCLES (STEP_CYCLES),
      .PULSE_MAX   (PULSE_MAX)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_first (load_first),
      .load_next  (load_next),
      .tick       (tick),
      .last_cycle (last_cycle),
      .last_pulse (last_pulse)
   );

   flash_op_sequencer u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op_e'(req_op)),
      .lock_hit    (lock_hit),
      .supply_ok   (supply_ok),
      .verify_pass (verify_pass),
      .last_cycle  (last_cycle),
      .last_pulse  (last_pulse),
      .load_first  (load_first),
      .load_next   (load_next),
      .tick        (tick),
      .mode_o      (mode),
      .erase_o     (is_erase),
      .evt_o       (evt),
      .abort_o     (op_abort)
   );

   flash_status_bits u_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .mode     (mode),
      .is_erase (is_erase),
      .status   (status)
   );

   assign ready = status[SB_READY];

endmodule

// File: rtl/flash_status_tracker_chk.sv
module flash_status_tracker_chk #(
   parameter int unsigned NUM_BLOCKS = 16,
   parameter int unsigned BLK_W      = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2:0]            req_op,
   input logic [BLK_W-1:0]      req_block,
   input logic [NUM_BLOCKS-1:0] lock_bits,
   input logic                  supply_ok,
   input logic [7:0]            status,
   input logic                  op_abort
);

   localparam logic [2:0] C_PROG  = 3'd1;
   localparam logic [2:0] C_ERASE = 3'd2;
   localparam logic [2:0] C_SUSP  = 3'd3;
   localparam logic [2:0] C_CLEAR = 3'd5;

   logic hit, idle, start_req, bad_req;

   always_comb begin
      hit = 1'b1;
      for (int i = 0; i < int'(NUM_BLOCKS); i++) begin
         if (int'(req_block) == i) hit = lock_bits[i];
      end
   end

   assign idle      = status[7] && !status[6] && !status[2];
   assign start_req = (req_op == C_PROG) || (req_op == C_ERASE);
   assign bad_req   = (req_op[2:1] == 2'b11);

   assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] == 1'b0);

   assert_single_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[6] && status[2]));

   assert_suspend_is_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status[6] || status[2]) |-> status[7]);

   assert_idle_suspend_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && req_op == C_SUSP) |=> (status[7] && !status[6] && !status[2]));

   assert_lock_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start_req && hit) |=> (status[1] && status[7] && op_abort));

   assert_abort_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_abort |-> (status[7] && (status[1] || status[3])));

   assert_supply_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start_req && !hit && !supply_ok) |=> (status[3] && status[7] && op_abort));

   assert_seq_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && bad_req) |=> (status[7] && status[5] && status[4]));

   assert_sticky_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && req_op != C_CLEAR) |=> status[1]);

   assert_sticky_vlow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3] && req_op != C_CLEAR) |=> status[3]);

   assert_sticky_perr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && req_op != C_CLEAR) |=> status[4]);

   assert_sticky_eerr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5] && req_op != C_CLEAR) |=> status[5]);

endmodule

bind flash_status_tracker flash_status_tracker_chk #(
   .NUM_BLOCKS (NUM_BLOCKS),
   .BLK_W      (BLK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_op    (req_op),
   .req_block (req_block),
   .lock_bits (lock_bits),
   .supply_ok (supply_ok),
   .status    (status),
   .op_abort  (op_abort)
);

// File: tb/flash_status_tracker_test.sv
module flash_status_tracker_test;

   localparam int unsigned NB   = 8;
   localparam int unsigned STEP = 3;
   localparam int unsigned PMAX = 4;
   localparam int unsigned BW   = 3;

   localparam logic [2:0] K_IDLE = 3'd0, K_PROG = 3'd1, K_ERASE = 3'd2, K_SUSP = 3'd3,
                          K_RES = 3'd4, K_CLR = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    op;
   logic [BW-1:0] blk;
   logic [NB-1:0] locks;
   logic          sup, ver;
   logic [7:0]    status;
   logic          ready, abort_o;

   always #10 clk = ~clk;

   flash_status_tracker #(
      .NUM_BLOCKS (NB),
      .STEP_CYCLES(STEP),
      .PULSE_MAX  (PMAX)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_op     (op),
      .req_block  (blk),
      .lock_bits  (locks),
      .supply_ok  (sup),
      .verify_pass(ver),
      .status     (status),
      .ready      (ready),
      .op_abort   (abort_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model: 0 ready, 1 busy, 2 suspended
   int m_mode, m_left, m_pulse;
   bit m_erase, m_lock, m_vlow, m_perr, m_eerr, m_abort;

   function automatic logic [7:0] exp_status();
      return {m_mode != 1, m_mode == 2 && m_erase, m_eerr, m_perr, m_vlow,
              m_mode == 2 && !m_erase, m_lock, 1'b0};
   endfunction

   function automatic string bit_req(input logic [7:0] d);
      if (d[7] === 1'b1) return "R2";
      if (d[6] === 1'b1 || d[2] === 1'b1) return "R3";
      if (d[5] === 1'b1) return "R5";
      if (d[4] === 1'b1) return "R4";
      if (d[3] === 1'b1) return "R7";
      if (d[1] === 1'b1) return "R6";
      return "R1";
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = 0; m_left = 0; m_pulse = 0;
      m_erase = 0; m_lock = 0; m_vlow = 0; m_perr = 0; m_eerr = 0; m_abort = 0;
   endtask

   task automatic model_step(input logic [2:0] o, input logic [BW-1:0] b, input logic s, input logic v);
      m_abort = 0;
      if (m_mode == 1) begin
         if (o == K_SUSP) m_mode = 2;
         else if (m_left > 1) m_left--;
         else if (!s) begin m_vlow = 1; m_abort = 1; m_mode = 0; end
         else if (v) m_mode = 0;
         else if (!m_erase) begin m_perr = 1; m_mode = 0; end
         else if (m_pulse == int'(PMAX)) begin m_eerr = 1; m_mode = 0; end
         else begin m_pulse++; m_left = STEP; end
      end else if (o == K_PROG || o == K_ERASE) begin
         if (m_mode == 2) begin m_perr = 1; m_eerr = 1; end
         else if (locks[b]) begin m_lock = 1; m_abort = 1; end
         else if (!s) begin m_vlow = 1; m_abort = 1; end
         else begin m_mode = 1; m_left = STEP; m_pulse = 1; m_erase = (o == K_ERASE); end
      end else if (o == K_RES) begin
         if (m_mode == 2) m_mode = 1;
      end else if (o == K_CLR) begin
         m_lock = 0; m_vlow = 0; m_perr = 0; m_eerr = 0;
      end else if (o[2:1] == 2'b11) begin
         m_perr = 1; m_eerr = 1;
      end
   endtask

   task automatic compare_model();
      logic [7:0] e;
      e = exp_status();
      n_chk++;
      if (status !== e || ready !== e[7]) begin
         n_bad++;
         $display("FAIL %s status actual=%0h expected=%0h", bit_req(status ^ e), status, e);
      end
      n_chk++;
      if (abort_o !== m_abort) begin
         n_bad++;
         $display("FAIL R6 op_abort actual=%0b expected=%0b", abort_o, m_abort);
      end
   endtask

   task automatic cyc(input logic [2:0] o, input logic [BW-1:0] b, input logic s, input logic v);
      op = o; blk = b; sup = s; ver = v;
      @(posedge clk);
      model_step(o, b, s, v);
      @(negedge clk);
      compare_model();
   endtask

   // pass_at: verify passes from pulse pass_at on; low_at: busy cycle with low supply
   task automatic run_busy(input int pass_at, input int low_at, output int n);
      n = 0;
      while (status[7] === 1'b0 && n < 1000) begin
         n++;
         cyc(K_IDLE, '0, n != low_at, n >= pass_at * int'(STEP));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; op = K_IDLE; blk = '0; locks = '0; sup = 1'b1; ver = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset status", status, 8'h80);
      check("R1 reset abort", abort_o, 0);

      // R2 plain program
      cyc(K_PROG, 3'd1, 1, 1);
      check("R2 busy after accept", status[7], 0);
      run_busy(0, 0, n);
      check("R2 program busy length", n, STEP);
      check("R2 program done", status, 8'h80);

      // R4 program verify failure
      cyc(K_PROG, 3'd1, 1, 0);
      run_busy(99, 0, n);
      check("R4 program failure", status, 8'h90);
      cyc(K_CLR, '0, 1, 1);
      check("R9 clear status", status, 8'h80);

      // R9 clear while busy ignored, sticky across operation
      cyc(K_PROG, 3'd1, 1, 0);
      run_busy(99, 0, n);
      cyc(K_PROG, 3'd2, 1, 1);
      cyc(K_CLR, '0, 1, 1);
      check("R9 clear ignored while busy", status, 8'h10);
      run_busy(0, 0, n);
      check("R9 error sticky across operation", status, 8'h90);
      cyc(K_CLR, '0, 1, 1);

      // R5 erase retries
      cyc(K_ERASE, 3'd2, 1, 0);
      run_busy(99, 0, n);
      check("R5 erase busy over all pulses", n, PMAX * STEP);
      check("R5 erase failure", status, 8'hA0);
      cyc(K_CLR, '0, 1, 1);
      cyc(K_ERASE, 3'd2, 1, 0);
      run_busy(2, 0, n);
      check("R5 erase passes on second pulse", n, 2 * STEP);
      check("R5 erase clean finish", status, 8'h80);

      // R6 locked block
      locks = 8'b0000_0100;
      cyc(K_PROG, 3'd2, 1, 1);
      check("R6 locked program", status, 8'h82);
      check("R6 abort pulse", abort_o, 1);
      cyc(K_IDLE, '0, 1, 1);
      check("R6 abort drops", abort_o, 0);
      cyc(K_ERASE, 3'd2, 1, 1);
      check("R6 locked erase stays ready", status, 8'h82);
      cyc(K_PROG, 3'd3, 1, 1);
      run_busy(0, 0, n);
      check("R9 lock bit sticky", status, 8'h82);
      cyc(K_CLR, '0, 1, 1);
      locks = '0;

      // R7 supply samples
      cyc(K_PROG, 3'd1, 0, 1);
      check("R7 low supply at accept", status, 8'h88);
      check("R7 abort at accept", abort_o, 1);
      cyc(K_CLR, '0, 1, 1);
      cyc(K_ERASE, 3'd1, 1, 1);
      run_busy(0, STEP, n);
      check("R7 low supply before verify", status, 8'h88);
      cyc(K_CLR, '0, 1, 1);
      cyc(K_PROG, 3'd1, 1, 1);
      run_busy(0, 1, n);
      check("R7 mid-step low ignored", status, 8'h80);
      check("R7 mid-step busy length", n, STEP);

      // R3 erase suspend and resume
      cyc(K_ERASE, 3'd0, 1, 1);
      cyc(K_IDLE, '0, 1, 1);
      cyc(K_SUSP, '0, 1, 1);
      check("R3 erase suspended", status, 8'hC0);
      repeat (5) cyc(K_IDLE, '0, 1, 1);
      check("R3 suspend flag holds", status, 8'hC0);
      cyc(K_PROG, 3'd1, 1, 1);
      check("R8 program while suspended", status, 8'hF0);
      cyc(K_CLR, '0, 1, 1);
      check("R9 clear keeps suspend", status, 8'hC0);
      cyc(K_RES, '0, 1, 1);
      check("R3 resume goes busy", status[7], 0);
      run_busy(0, 0, n);
      check("R3 remaining step after resume", n, STEP - 1);
      check("R3 erase done", status, 8'h80);

      // R3 program suspend on the final cycle wins over completion
      cyc(K_PROG, 3'd1, 1, 0);
      cyc(K_IDLE, '0, 1, 0);
      cyc(K_IDLE, '0, 1, 0);
      cyc(K_SUSP, '0, 1, 0);
      check("R3 suspend wins at step end", status, 8'h84);
      cyc(K_RES, '0, 1, 0);
      run_busy(99, 0, n);
      check("R3 one cycle left after resume", n, 1);
      check("R4 failure after resume", status, 8'h90);
      cyc(K_CLR, '0, 1, 1);

      // R3 ignored suspend and resume
      cyc(K_SUSP, '0, 1, 1);
      check("R3 suspend while ready ignored", status, 8'h80);
      cyc(K_RES, '0, 1, 1);
      check("R3 resume without suspend ignored", status, 8'h80);

      // R8 invalid codes
      cyc(3'd6, '0, 1, 1);
      check("R8 invalid code 6", status, 8'hB0);
      cyc(K_CLR, '0, 1, 1);
      cyc(3'd7, '0, 1, 1);
      check("R8 invalid code 7", status, 8'hB0);
      cyc(K_CLR, '0, 1, 1);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [2:0] o;
         r = $urandom_range(0, 99);
         if (r < 60) o = K_IDLE;
         else if (r < 70) o = K_PROG;
         else if (r < 78) o = K_ERASE;
         else if (r < 86) o = K_SUSP;
         else if (r < 93) o = K_RES;
         else if (r < 98) o = K_CLR;
         else o = 3'($urandom_range(6, 7));
         if ($urandom_range(0, 199) == 0) locks = NB'($urandom);
         cyc(o, BW'($urandom), $urandom_range(0, 9) != 0, $urandom_range(0, 9) < 6);
      end

      summary();
      $finish;
   end

endmodule